// File: doc/BRIEF.md
# Serial Boot Download Controller

This block runs the serial download path that a chip can take right after reset. When the internal reset is released it samples two boot-select pins once and keeps that value as the boot mode. Only one pin combination selects the serial download path. In every other combination the controller stays idle and only reports the mode it decoded. On the serial path it first checks a debug-protection input. If protection is set, it parks for good. If not, it times the low period of a zero byte on the raw receive line and turns that time into a UART baud divisor.

With the divisor ready, the controller enables the UART engine through `uart_en`/`baud_div`. It offers a fixed acknowledge byte on a byte-level transmit handshake. Only after that byte is taken does it accept a fixed number of received bytes. The bytes are packed into 32-bit words and written to RAM at rising word addresses from a load base. After the last write the controller holds a jump request carrying the load base, so the CPU can start running the downloaded code. There is no timeout at any step. The UART bit engines and the CPU sit outside this block.

Top module: `sboot_ctrl`

## Requirements
- R1: `boot_mode` reads 2'b00 during reset. On the first clock after the synchronised reset release it takes the value {`mode_hi`,`mode_lo`}, and it keeps that value until the next reset, whatever the pins do later.
- R2: In boot modes 2'b00, 2'b01 (user boot) and 2'b11 (reserved), `uart_en`, `tx_valid`, `rx_ready`, `ram_we`, `jump_req` and `prot_park` all stay 0, even while `rx_line` is toggling.
- R3: In boot mode 2'b10 (serial download), if `prot_i` is 1 on the check cycle the controller raises `prot_park` and keeps it up. No measurement, acknowledge, load or jump follows, even if `prot_i` drops later.
- R4: In serial mode, `rx_line` may go low and then return high after L clock cycles. The controller then sets `uart_en` and holds `baud_div` = floor(L/144), since the zero byte spans 9 bit times of 16 samples each.
- R5: If `rx_line` stays low for more than 2^CNT_W-1 cycles, that measurement is thrown away and `uart_en` stays 0. The next falling edge starts a fresh measurement.
- R6: Once `uart_en` is set, `tx_valid` stays at 1 with `tx_data` = 8'h95 until `tx_ready` is seen. `rx_ready` stays 0 until that handshake has happened.
- R7: Exactly 128 bytes are accepted, each on a cycle where `rx_valid` and `rx_ready` are both 1. `rx_ready` falls after the 128th, and later bytes are never taken.
- R8: Bytes are packed little-endian: byte 4k+j lands in bits [8j+7:8j] of word k. A one-cycle `ram_we` pulse writes word k to `ram_addr` = 32'hA000_0000 + 4k, in rising k order, on the cycle after its fourth byte is accepted.
- R9: `jump_req` rises on the cycle after the last `ram_we` pulse and then stays high, with `jump_addr` = 32'hA000_0000.
- R10: There is no timeout. Any gap before a byte, including gaps of thousands of cycles, leaves the load sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_hi | input | 1 | Boot-select pin, upper bit of the mode |
| mode_lo | input | 1 | Boot-select pin, lower bit of the mode |
| prot_i | input | 1 | Debug protection active |
| rx_line | input | 1 | Raw serial receive line, used to time the zero byte |
| uart_en | output | 1 | Baud divisor valid, UART engine may run |
| baud_div | output | CNT_W | Measured baud divisor |
| tx_valid | output | 1 | Acknowledge byte offered |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| rx_valid | input | 1 | Receiver has a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Controller accepts a received byte |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | 32 | RAM byte address of the word |
| ram_wdata | output | 32 | RAM write word |
| jump_req | output | 1 | Request to execute the downloaded code |
| jump_addr | output | 32 | Address to execute from |
| boot_mode | output | 2 | Latched boot mode |
| prot_park | output | 1 | Parked because protection is active |

## Verification
The in-line assertions check these properties on every cycle: the latched mode is stable, non-serial modes stay quiet, the park state and the jump request are sticky, the acknowledge offer is held until it is taken, nothing is received before the acknowledge, and write strobes never appear on back-to-back cycles. Only the bench's scenarios can show the values that depend on the data. These are the divisor that comes out of a given low time (including an exact multiple of 144 and a discarded overlong pulse), the order of bytes inside each packed word and the address of each word, the exact count of 128 accepted bytes, and the one-cycle gap between the last write and the jump.

// File: rtl/sboot_pkg.sv
package sboot_pkg;
  localparam logic [1:0] MODE_USER0  = 2'b00;
  localparam logic [1:0] MODE_USER1  = 2'b01;
  localparam logic [1:0] MODE_SERIAL = 2'b10;
  localparam logic [1:0] MODE_RSVD   = 2'b11;

  typedef enum logic [3:0] {
    S_CAP, S_CHECK, S_OFF, S_PARK, S_MEAS, S_ACK, S_LOAD, S_FLUSH, S_JUMP
  } boot_st_e;

  typedef enum logic [1:0] {AB_ARM, AB_CNT, AB_DIV, AB_DONE} ab_st_e;
endpackage

// File: rtl/sboot_autobaud.sv
module sboot_autobaud
  import sboot_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_FACTOR = 144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_en,
  input  logic             rx_line,
  output logic             done,
  output logic [CNT_W-1:0] div
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FACTOR  = CNT_W'(DIV_FACTOR);

  logic rx_s1, rx_s2, rx_prev;
  logic fall, rise;
  ab_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, quo_q, quo_d;

  // Two-flop synchroniser plus previous-value register for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_s1   <= rx_line;
      rx_s2   <= rx_s1;
      rx_prev <= rx_s2;
    end
  end

  assign fall = rx_prev & ~rx_s2;
  assign rise = ~rx_prev & rx_s2;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    quo_d = quo_q;
    case (st_q)
      AB_ARM: if (start_en && fall) begin
        st_d  = AB_CNT;
        cnt_d = CNT_W'(1);
      end
      AB_CNT: begin
        if (rise) begin
          st_d  = AB_DIV;
          quo_d = '0;
        end else if (cnt_q == CNT_MAX) begin
          st_d = AB_ARM;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      AB_DIV: begin
        if (cnt_q >= FACTOR) begin
          cnt_d = cnt_q - FACTOR;
          quo_d = quo_q + CNT_W'(1);
        end else begin
          st_d = AB_DONE;
        end
      end
      default: st_d = AB_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= AB_ARM;
      cnt_q <= '0;
      quo_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      quo_q <= quo_d;
    end
  end

  assign done = (st_q == AB_DONE);
  assign div  = done ? quo_q : '0;

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(div));

  assert_count_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AB_CNT) |-> (cnt_q != '0));
endmodule

// File: rtl/sboot_packer.sv
module sboot_packer #(
  parameter int          NUM_BYTES = 128,
  parameter logic [31:0] LOAD_BASE = 32'hA000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [7:0]  byte_in,
  output logic        last,
  output logic        ram_we,
  output logic [31:0] ram_addr,
  output logic [31:0] ram_wdata
);
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [23:0]      hold_q;
  logic             we_q, full_q;
  logic [31:0]      addr_q, data_q;
  logic             word_end, take_en;

  assign take_en  = take && !full_q;
  assign word_end = (idx_q[1:0] == 2'b11);
  assign last     = take_en && (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else if (take_en) begin
      idx_q  <= idx_q + IDX_W'(1);
      full_q <= (idx_q == IDX_LAST);
    end
  end

  // Lower three bytes of the current word wait here until the fourth arrives
  for (genvar g = 0; g < 3; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[8*g +: 8] <= '0;
      else if (take_en && idx_q[1:0] == 2'(g)) hold_q[8*g +: 8] <= byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= take_en && word_end;
      if (take_en && word_end) begin
        addr_q <= LOAD_BASE + (32'(idx_q[IDX_W-1:2]) << 2);
        data_q <= {byte_in, hold_q};
      end
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;

  assert_we_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);

  assert_no_take_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(idx_q) && !ram_we);
endmodule

// File: rtl/sboot_ctrl.sv
module sboot_ctrl
  import sboot_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          DIV_FACTOR = 144,
  parameter int          NUM_BYTES  = 128,
  parameter logic [31:0] LOAD_BASE  = 32'hA000_0000,
  parameter logic [7:0]  ACK_BYTE   = 8'h95
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_hi,
  input  logic             mode_lo,
  input  logic             prot_i,
  input  logic             rx_line,
  output logic             uart_en,
  output logic [CNT_W-1:0] baud_div,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             ram_we,
  output logic [31:0]      ram_addr,
  output logic [31:0]      ram_wdata,
  output logic             jump_req,
  output logic [31:0]      jump_addr,
  output logic [1:0]       boot_mode,
  output logic             prot_park
);
  logic rst_s1, rst_sn;
  boot_st_e st_q, st_d;
  logic [1:0] mode_q;
  logic cap_en, ab_done, pk_last, ack_sent, ack_fire;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  assign cap_en   = (st_q == S_CAP);
  assign ack_fire = (st_q == S_ACK) && tx_ready;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) mode_q <= MODE_USER0;
    else if (cap_en) mode_q <= {mode_hi, mode_lo};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ack_sent <= 1'b0;
    else if (ack_fire) ack_sent <= 1'b1;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_CAP:   st_d = ({mode_hi, mode_lo} == MODE_SERIAL) ? S_CHECK : S_OFF;
      S_CHECK: st_d = prot_i ? S_PARK : S_MEAS;
      S_MEAS:  if (ab_done) st_d = S_ACK;
      S_ACK:   if (tx_ready) st_d = S_LOAD;
      S_LOAD:  if (pk_last) st_d = S_FLUSH;
      S_FLUSH: st_d = S_JUMP;
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= S_CAP;
    else         st_q <= st_d;
  end

  sboot_autobaud #(.CNT_W(CNT_W), .DIV_FACTOR(DIV_FACTOR)) u_baud (
    .clk      (clk),
    .rst_n    (rst_sn),
    .start_en (st_q == S_MEAS),
    .rx_line  (rx_line),
    .done     (ab_done),
    .div      (baud_div)
  );

  sboot_packer #(.NUM_BYTES(NUM_BYTES), .LOAD_BASE(LOAD_BASE)) u_pack (
    .clk       (clk),
    .rst_n     (rst_sn),
    .take      (rx_valid && rx_ready),
    .byte_in   (rx_data),
    .last      (pk_last),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  assign uart_en   = ab_done;
  assign tx_valid  = (st_q == S_ACK);
  assign tx_data   = tx_valid ? ACK_BYTE : 8'h00;
  assign rx_ready  = (st_q == S_LOAD);
  assign jump_req  = (st_q == S_JUMP);
  assign jump_addr = jump_req ? LOAD_BASE : 32'h0;
  assign boot_mode = mode_q;
  assign prot_park = (st_q == S_PARK);

  assert_mode_stable_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q != S_CAP) |=> $stable(boot_mode));

  assert_inactive_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q != S_CAP && boot_mode != MODE_SERIAL)
      |-> !(uart_en || tx_valid || rx_ready || ram_we || jump_req || prot_park));

  assert_park_sticky_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    prot_park |=> prot_park && !uart_en && !tx_valid && !rx_ready);

  assert_ack_held_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (tx_valid && !tx_ready) |=> tx_valid && (tx_data == ACK_BYTE));

  assert_rx_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_ready |-> ack_sent && uart_en);

  assert_jump_sticky_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    jump_req |=> jump_req && (jump_addr == LOAD_BASE) && !rx_ready);
endmodule

// File: tb/tb_sboot_ctrl.sv
module tb_sboot_ctrl;
  localparam int CW = 12;
  localparam logic [31:0] BASE = 32'hA000_0000;

  logic clk = 1'b0;
  logic rst_n, mode_hi, mode_lo, prot_i, rx_line;
  logic uart_en, tx_valid, tx_ready, rx_valid, rx_ready;
  logic ram_we, jump_req, prot_park;
  logic [CW-1:0] baud_div;
  logic [7:0] tx_data, rx_data;
  logic [31:0] ram_addr, ram_wdata, jump_addr;
  logic [1:0] boot_mode;

  int checks = 0, errors = 0, cyc = 0;
  int nw = 0, last_we_cyc = 0, jump_cyc = 0;
  bit jump_seen = 0, done = 0;
  logic [31:0] wa [40];
  logic [31:0] wd [40];

  always #2.5 clk = ~clk;

  sboot_ctrl #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .prot_i(prot_i), .rx_line(rx_line), .uart_en(uart_en), .baud_div(baud_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .jump_req(jump_req), .jump_addr(jump_addr), .boot_mode(boot_mode),
    .prot_park(prot_park)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (ram_we) begin
      if (nw < 40) begin
        wa[nw] = ram_addr;
        wd[nw] = ram_wdata;
      end
      nw++;
      last_we_cyc = cyc;
    end
    if (jump_req && !jump_seen) begin
      jump_seen = 1;
      jump_cyc  = cyc;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 8'hff);
  endfunction

  task automatic do_reset(input logic hi, input logic lo, input logic pr);
    @(negedge clk);
    rst_n = 1'b0; mode_hi = hi; mode_lo = lo; prot_i = pr;
    rx_line = 1'b1; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    nw = 0; jump_seen = 0;
  endtask

  task automatic zero_pulse(input int len);
    rx_line = 1'b0;
    repeat (len) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic wait_uart(input int limit);
    for (int i = 0; i < limit && !uart_en; i++) @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0; mode_hi = 1'b1; mode_lo = 1'b1; prot_i = 1'b0;
    rx_line = 1'b1; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "boot_mode in reset", 64'(boot_mode), 64'd0);
    chk("R2", "outputs quiet in reset",
        64'({uart_en, tx_valid, rx_ready, ram_we, jump_req, prot_park}), 64'd0);
  endtask

  task automatic t_user_modes;
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      do_reset(m[1], m[0], 1'b0);
      chk("R1", "latched mode", 64'(boot_mode), 64'(m));
      mode_hi = 1'b1; mode_lo = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1", "mode after pin change", 64'(boot_mode), 64'(m));
      zero_pulse(1440);
      repeat (600) @(negedge clk);
      chk("R2", "inactive mode stays quiet",
          64'({uart_en, tx_valid, rx_ready, ram_we, jump_req, prot_park}), 64'd0);
    end
  endtask

  task automatic t_protect;
    do_reset(1'b1, 1'b0, 1'b1);
    chk("R3", "parked", 64'(prot_park), 64'd1);
    prot_i = 1'b0;
    zero_pulse(1440);
    repeat (600) @(negedge clk);
    chk("R3", "still parked", 64'(prot_park), 64'd1);
    chk("R3", "no baud, ack or load", 64'({uart_en, tx_valid, rx_ready, jump_req}), 64'd0);
  endtask

  task automatic t_overflow;
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R1", "serial mode latched", 64'(boot_mode), 64'd2);
    zero_pulse(5000);
    repeat (100) @(negedge clk);
    chk("R5", "overlong pulse discarded", 64'(uart_en), 64'd0);
    zero_pulse(1000);
    wait_uart(100);
    chk("R5", "remeasure after overflow", 64'(uart_en), 64'd1);
    chk("R4", "divisor floor(1000/144)", 64'(baud_div), 64'd6);
  endtask

  task automatic t_exact_multiple;
    do_reset(1'b1, 1'b0, 1'b0);
    zero_pulse(287);
    wait_uart(50);
    chk("R4", "divisor floor(287/144)", 64'(baud_div), 64'd1);
    do_reset(1'b1, 1'b0, 1'b0);
    zero_pulse(288);
    wait_uart(50);
    chk("R4", "divisor 288/144", 64'(baud_div), 64'd2);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    for (int i = 0; i < 20 && !rx_ready; i++) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_full_boot;
    logic ok;
    do_reset(1'b1, 1'b0, 1'b0);
    zero_pulse(1440);
    wait_uart(100);
    chk("R4", "uart enabled", 64'(uart_en), 64'd1);
    chk("R4", "divisor 1440/144", 64'(baud_div), 64'd10);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hEE;
    repeat (10) @(negedge clk);
    chk("R6", "ack offered", 64'({tx_valid, tx_data}), 64'h195);
    chk("R6", "no rx before ack", 64'(rx_ready), 64'd0);
    chk("R6", "no write before ack", 64'(nw), 64'd0);
    rx_valid = 1'b0;
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6", "ack taken, rx open", 64'({tx_valid, rx_ready}), 64'b01);
    for (int i = 0; i < 128; i++)
      send_byte(pat(i), (i == 50) ? 3000 : (i % 3));
    repeat (3) @(negedge clk);
    chk("R10", "long gap tolerated, jump reached", 64'(jump_req), 64'd1);
    chk("R7", "rx closed after 128", 64'(rx_ready), 64'd0);
    rx_valid = 1'b1; rx_data = 8'h5A;
    repeat (10) @(negedge clk);
    rx_valid = 1'b0;
    chk("R7", "word writes for 128 bytes", 64'(nw), 64'd32);
    ok = 1'b1;
    for (int k = 0; k < 32; k++) begin
      if (wa[k] !== BASE + 32'(4 * k)) begin
        ok = 1'b0;
        chk("R8", "word address", 64'(wa[k]), 64'(BASE + 32'(4 * k)));
      end
      if (wd[k] !== {pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)}) begin
        ok = 1'b0;
        chk("R8", "word data little-endian", 64'(wd[k]),
            64'({pat(4*k+3), pat(4*k+2), pat(4*k+1), pat(4*k)}));
      end
    end
    chk("R8", "all words addressed and packed", 64'(ok), 64'd1);
    chk("R9", "jump one cycle after last write", 64'(jump_cyc), 64'(last_we_cyc + 1));
    chk("R9", "jump address", 64'(jump_addr), 64'(BASE));
    repeat (20) @(negedge clk);
    chk("R9", "jump held", 64'(jump_req), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; mode_hi = 1'b0; mode_lo = 1'b0; prot_i = 1'b0;
    rx_line = 1'b1; tx_ready = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    t_reset_state();
    t_user_modes();
    t_protect();
    t_overflow();
    t_exact_multiple();
    t_full_boot();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule